// File: doc/BRIEF.md
# Split Serial Access Buffer Controller

This block owns a 512-entry, 8-bit serial buffer that sits between a memory row and a serial data port. Transfer commands move data between the row and the buffer. A full transfer moves all 512 entries. A split transfer moves the 256 entries of whichever half is not being served at that moment. Transfers walk the row one entry per clock through a simple external row port: an address, a write strobe, write data, and combinational read data.

A single-cycle serial pulse, qualified by the system clock, steps a circular pointer through the buffer. In output mode the pointer's entry appears on the serial output. In input mode each pulse stores the serial input byte at the pointer. An enable input gates only the data and never the stepping.

In split mode the pointer runs to the last entry of its half and then jumps to a tap stored for the other half. A half flag always names the half in use. Split commands are screened before they start, and any refused command raises a one-cycle error.

Top module: `sab_split_buffer`

## Requirements
- R1: A full read (cmd_kind 2'b00) or full write (2'b01) that is accepted drops xfer_ready for exactly 512 cycles and walks row_addr from 0 to 511. Serial pulses that arrive during a full transfer do not move the pointer. A full read stores row entry i into buffer entry i.
- R2: When a full transfer ends, the pointer is loaded with that command's 9-bit tap. Each later serial pulse advances the pointer by one, and 511 wraps to 0. In output mode with ser_en high, ser_dout shows the entry at the pointer.
- R3: With ser_en low, serial pulses still advance the pointer. ser_dout then reads 0, and in input mode nothing is stored.
- R4: ser_dir reads 1 (output) after reset and after a full read, and 0 (input) after a full write. Split transfers never change it. In input mode with ser_en high, each serial pulse stores ser_din at the pointer.
- R5: half_flag is 0 while the pointer is in entries 0..255 and 1 while it is in entries 256..511. It changes on the very pulse that crosses between the halves.
- R6: After a split transfer has completed, a pulse taken at the last entry of the active half (low 8 pointer bits all ones) moves the pointer to the stored 8-bit split tap in the other half. half_flag toggles on that same pulse.
- R7: A split read (2'b10) or split write (2'b11) works on the half opposite half_flag at acceptance. It holds xfer_ready low for 256 cycles. Serial stepping and serial data on the active half continue throughout.
- R8: A full write copies buffer entry i to row entry i with row_we high. A split write does the same for the 256 entries of its half.
- R9: A split command whose tap has low 8 bits equal to 8'hFF is refused.
- R10: A split read is refused unless a full read was the last full transfer. A split write is refused unless a full write was the last full transfer.
- R11: A split command is refused while fewer than gap_min clocks have passed since half_flag last changed (count saturating at 255).
- R12: Any command presented while xfer_ready is low is refused. A refused command changes no state and sets cmd_err high for exactly the next cycle.
- R13: After reset, xfer_ready is 1, cmd_err is 0, ser_dir is 1, half_flag is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| cmd_valid | input | 1 | Transfer command strobe |
| cmd_kind | input | 2 | 00 full read, 01 full write, 10 split read, 11 split write |
| cmd_tap | input | 9 | Start tap of the command |
| gap_min | input | 8 | Minimum clocks after a half change before a split is accepted |
| sc_pulse | input | 1 | Serial step, one clock wide |
| ser_en | input | 1 | Serial data enable |
| ser_din | input | 8 | Serial write data |
| ser_dout | output | 8 | Serial read data |
| ser_dir | output | 1 | 1 output mode, 0 input mode |
| half_flag | output | 1 | Active half of the buffer |
| xfer_ready | output | 1 | High when no transfer is running |
| cmd_err | output | 1 | One-cycle pulse after a refused command |
| row_addr | output | 9 | Row entry being transferred |
| row_we | output | 1 | Row write strobe |
| row_wdata | output | 8 | Data written to the row |
| row_rdata | input | 8 | Row data at row_addr |

## Verification
The first stimulus is a full read from a tap near the top of the buffer, followed by a dense pulse train. Gated and ungated pulses are mixed in it. This separates a pointer that wraps correctly and keeps stepping while gated from one that stalls or stops at 511.

Split reads are then issued while the active half is still streaming. This is done with the row contents changed between transfers, so data read after a jump proves that the correct half was refilled and the correct tap was taken. Serial writes in input mode are followed by split and full writes and a read-back. Together these expose a wrong target half, a misplaced serial write, or a write that leaked while the enable was low.

Each refusal condition is hit on its own, and then once with a command that would otherwise be legal. This shows that each condition refuses the command alone and does not disturb state.

// File: rtl/sab_pkg.sv
package sab_pkg;
  typedef enum logic [1:0] {
    XF_FULL_RD  = 2'b00,
    XF_FULL_WR  = 2'b01,
    XF_SPLIT_RD = 2'b10,
    XF_SPLIT_WR = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/sab_store.sv
module sab_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              xw_en,
  input  logic [ADDR_W-1:0] xw_addr,
  input  logic [DATA_W-1:0] xw_data,
  input  logic              sw_en,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // transfer port is written last so it wins on a shared address
  always_ff @(posedge clk) begin
    if (sw_en) mem[sw_addr] <= sw_data;
    if (xw_en) mem[xw_addr] <= xw_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/sab_ptr.sv
module sab_ptr #(
  parameter int ADDR_W = 9,
  parameter int GAP_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sc_pulse,
  input  logic                hold,
  input  logic                load,
  input  logic [ADDR_W-1:0]   load_tap,
  input  logic                split_set,
  input  logic [ADDR_W-2:0]   split_tap,
  input  logic [GAP_W-1:0]    gap_min,
  output logic [ADDR_W-1:0]   ptr,
  output logic                split_mode,
  output logic                gap_ok
);
  localparam int HALF_W = ADDR_W - 1;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [HALF_W-1:0] stap_q, stap_d;
  logic              split_q, split_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              adv, at_end;

  assign adv    = sc_pulse & ~hold;
  assign at_end = split_q & (ptr_q[HALF_W-1:0] == {HALF_W{1'b1}});

  always_comb begin
    ptr_d   = ptr_q;
    stap_d  = stap_q;
    split_d = split_q;
    if (load)
      ptr_d = load_tap;
    else if (adv)
      ptr_d = at_end ? {~ptr_q[ADDR_W-1], stap_q} : ptr_q + 1'b1;
    if (load)      split_d = 1'b0;
    if (split_set) begin
      split_d = 1'b1;
      stap_d  = split_tap;
    end
    if (ptr_d[ADDR_W-1] != ptr_q[ADDR_W-1])
      gap_d = '0;
    else if (gap_q != {GAP_W{1'b1}})
      gap_d = gap_q + 1'b1;
    else
      gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      stap_q  <= '0;
      split_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      ptr_q   <= ptr_d;
      stap_q  <= stap_d;
      split_q <= split_d;
      gap_q   <= gap_d;
    end
  end

  assign ptr        = ptr_q;
  assign split_mode = split_q;
  assign gap_ok     = (gap_q >= gap_min);
endmodule

// File: rtl/sab_xfer_seq.sv
module sab_xfer_seq
  import sab_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  xfer_kind_e        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_tap,
  input  logic              gap_ok,
  input  logic              act_half,
  output logic              busy,
  output logic              full_busy,
  output logic              done_full,
  output logic              done_split,
  output logic [ADDR_W-1:0] xf_tap,
  output logic [ADDR_W-1:0] xf_addr,
  output logic              xf_load,
  output logic              xf_store,
  output logic              ser_dir,
  output logic              cmd_err
);
  localparam int HALF_W = ADDR_W - 1;

  logic              busy_q, busy_d, full_q, full_d, rd_q, rd_d, half_q, half_d;
  logic              dir_q, dir_d, primed_q, primed_d, err_q, err_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d, tap_q, tap_d, last;
  logic              is_split, is_wr, refuse, accept, done;

  assign is_split = (cmd_kind == XF_SPLIT_RD) || (cmd_kind == XF_SPLIT_WR);
  assign is_wr    = (cmd_kind == XF_FULL_WR)  || (cmd_kind == XF_SPLIT_WR);

  always_comb begin
    refuse = busy_q;
    if (is_split)
      refuse = refuse | (cmd_tap[HALF_W-1:0] == {HALF_W{1'b1}}) | ~primed_q
                      | (is_wr == dir_q) | ~gap_ok;
  end

  assign accept = cmd_valid & ~refuse;
  assign last   = full_q ? {ADDR_W{1'b1}} : {1'b0, {HALF_W{1'b1}}};
  assign done   = busy_q & (cnt_q == last);

  always_comb begin
    busy_d   = busy_q;
    full_d   = full_q;
    rd_d     = rd_q;
    half_d   = half_q;
    cnt_d    = cnt_q;
    tap_d    = tap_q;
    dir_d    = dir_q;
    primed_d = primed_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        if (full_q) begin
          dir_d    = rd_q;
          primed_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (accept) begin
      busy_d = 1'b1;
      full_d = ~is_split;
      rd_d   = ~is_wr;
      half_d = ~act_half;
      cnt_d  = '0;
      tap_d  = cmd_tap;
    end
    err_d = cmd_valid & refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      full_q   <= 1'b0;
      rd_q     <= 1'b0;
      half_q   <= 1'b0;
      cnt_q    <= '0;
      tap_q    <= '0;
      dir_q    <= 1'b1;
      primed_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      full_q   <= full_d;
      rd_q     <= rd_d;
      half_q   <= half_d;
      cnt_q    <= cnt_d;
      tap_q    <= tap_d;
      dir_q    <= dir_d;
      primed_q <= primed_d;
      err_q    <= err_d;
    end
  end

  assign busy       = busy_q;
  assign full_busy  = busy_q & full_q;
  assign done_full  = done & full_q;
  assign done_split = done & ~full_q;
  assign xf_tap     = tap_q;
  assign xf_addr    = full_q ? cnt_q : {half_q, cnt_q[HALF_W-1:0]};
  assign xf_load    = busy_q & rd_q;
  assign xf_store   = busy_q & ~rd_q;
  assign ser_dir    = dir_q;
  assign cmd_err    = err_q;
endmodule

// File: rtl/sab_split_buffer.sv
module sab_split_buffer #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_tap,
  input  logic [GAP_W-1:0]  gap_min,
  input  logic              sc_pulse,
  input  logic              ser_en,
  input  logic [DATA_W-1:0] ser_din,
  output logic [DATA_W-1:0] ser_dout,
  output logic              ser_dir,
  output logic              half_flag,
  output logic              xfer_ready,
  output logic              cmd_err,
  output logic [ADDR_W-1:0] row_addr,
  output logic              row_we,
  output logic [DATA_W-1:0] row_wdata,
  input  logic [DATA_W-1:0] row_rdata
);
  localparam int HALF_W = ADDR_W - 1;

  logic              rst_meta, rst_sync;
  logic              busy, full_busy, done_full, done_split, xf_load, xf_store;
  logic              split_mode, gap_ok, ser_wr;
  logic [ADDR_W-1:0] ptr, xf_tap, xf_addr;
  logic [DATA_W-1:0] ser_rd;
  sab_pkg::xfer_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign kind = sab_pkg::xfer_kind_e'(cmd_kind);

  sab_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync), .cmd_valid(cmd_valid), .cmd_kind(kind),
    .cmd_tap(cmd_tap), .gap_ok(gap_ok), .act_half(ptr[ADDR_W-1]),
    .busy(busy), .full_busy(full_busy), .done_full(done_full),
    .done_split(done_split), .xf_tap(xf_tap), .xf_addr(xf_addr),
    .xf_load(xf_load), .xf_store(xf_store), .ser_dir(ser_dir), .cmd_err(cmd_err)
  );

  sab_ptr #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync), .sc_pulse(sc_pulse), .hold(full_busy),
    .load(done_full), .load_tap(xf_tap), .split_set(done_split),
    .split_tap(xf_tap[HALF_W-1:0]), .gap_min(gap_min), .ptr(ptr),
    .split_mode(split_mode), .gap_ok(gap_ok)
  );

  assign ser_wr = sc_pulse & ser_en & ~ser_dir & ~full_busy;

  sab_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .xw_en(xf_load), .xw_addr(xf_addr), .xw_data(row_rdata),
    .sw_en(ser_wr), .sw_addr(ptr), .sw_data(ser_din),
    .ra_addr(xf_addr), .ra_data(row_wdata), .rb_addr(ptr), .rb_data(ser_rd)
  );

  assign ser_dout   = (ser_en & ser_dir) ? ser_rd : '0;
  assign half_flag  = ptr[ADDR_W-1];
  assign xfer_ready = ~busy;
  assign row_addr   = xf_addr;
  assign row_we     = xf_store;
endmodule

// File: rtl/sab_chk.sv
module sab_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_tap,
  input logic              xfer_ready,
  input logic              cmd_err,
  input logic              row_we,
  input logic              half_flag,
  input logic              ser_dir,
  input logic              sc_pulse,
  input logic              full_busy,
  input logic              done_full,
  input logic              split_mode,
  input logic [ADDR_W-1:0] ptr
);
  localparam int HW = ADDR_W - 1;

  AST_BUSY_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && !xfer_ready) |=> cmd_err); // R12
  AST_SPLIT_END_TAP_REFUSED: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && cmd_kind[1] && (cmd_tap[HW-1:0] == {HW{1'b1}})) |=> cmd_err); // R9
  AST_FULL_XFER_FREEZES_PTR: assert property (@(posedge clk) disable iff (!rst_ni)
    (full_busy && !done_full) |=> $stable(ptr)); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (!split_mode && sc_pulse && !full_busy) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R2
  AST_HALF_CROSS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (!split_mode && sc_pulse && !full_busy && (ptr[HW-1:0] == {HW{1'b1}}))
      |=> (half_flag != $past(half_flag))); // R5
  AST_SPLIT_JUMP_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (split_mode && sc_pulse && !full_busy && (ptr[HW-1:0] == {HW{1'b1}}))
      |=> (half_flag != $past(half_flag))); // R6
  AST_DIR_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    !done_full |=> $stable(ser_dir)); // R4
  AST_ROW_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    row_we |-> !xfer_ready); // R8
endmodule

bind sab_split_buffer sab_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ni(rst_sync), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_tap(cmd_tap), .xfer_ready(xfer_ready), .cmd_err(cmd_err), .row_we(row_we),
  .half_flag(half_flag), .ser_dir(ser_dir), .sc_pulse(sc_pulse),
  .full_busy(full_busy), .done_full(done_full), .split_mode(split_mode), .ptr(ptr)
);

// File: tb/sab_split_buffer_bench.sv
module sab_split_buffer_bench;
  localparam int N = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_kind;
  logic [8:0] cmd_tap;
  logic [7:0] gap_min;
  logic       sc_pulse, ser_en;
  logic [7:0] ser_din, ser_dout, row_wdata, row_rdata;
  logic       ser_dir, half_flag, xfer_ready, cmd_err, row_we;
  logic [8:0] row_addr;

  always #2 clk = ~clk;

  sab_split_buffer u_sab_split_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_tap(cmd_tap), .gap_min(gap_min), .sc_pulse(sc_pulse), .ser_en(ser_en),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_dir(ser_dir), .half_flag(half_flag),
    .xfer_ready(xfer_ready), .cmd_err(cmd_err), .row_addr(row_addr), .row_we(row_we),
    .row_wdata(row_wdata), .row_rdata(row_rdata)
  );

  // external row: env_op 1 = initialise, 2 = add 8'h40 to every entry
  logic [7:0] row_mem [N];
  int env_op = 0;
  assign row_rdata = row_mem[row_addr];
  always @(posedge clk) begin
    if (env_op == 1)      for (int i = 0; i < N; i++) row_mem[i] <= 8'((i * 7 + 3) % 256);
    else if (env_op == 2) for (int i = 0; i < N; i++) row_mem[i] <= row_mem[i] + 8'h40;
    else if (row_we)      row_mem[row_addr] <= row_wdata;
  end

  // reference model state
  int m_buf [N];
  int m_row [N];
  int m_ptr, m_gap, m_cnt, m_last, m_tap, m_half, m_stap, m_hold;
  bit m_dir, m_primed, m_split, m_busy, m_full, m_rd, m_err;
  int vecs = 0, fails = 0;
  bit finished = 0;

  task automatic model_step();
    int a, old_msb, nptr;
    bit done, refuse, accept, adv, is_split, is_wr;
    if (m_hold > 0) begin m_hold--; return; end
    a = 0;
    done     = m_busy && (m_cnt == m_last);
    is_split = cmd_kind[1];
    is_wr    = cmd_kind[0];
    refuse   = m_busy;
    if (is_split)
      refuse = refuse || (cmd_tap % 256 == 255) || !m_primed || (is_wr == m_dir) || (m_gap < int'(gap_min));
    accept = cmd_valid && !refuse;
    if (m_busy) a = m_full ? m_cnt : m_half * 256 + m_cnt;
    if (m_busy && !m_rd) m_row[a] = m_buf[a];
    adv = sc_pulse && !(m_busy && m_full);
    if (adv && ser_en && !m_dir) m_buf[m_ptr] = int'(ser_din);
    if (m_busy && m_rd) m_buf[a] = m_row[a];
    old_msb = m_ptr / 256;
    nptr = m_ptr;
    if (done && m_full) nptr = m_tap;
    else if (adv) nptr = (m_split && (m_ptr % 256 == 255)) ? (1 - old_msb) * 256 + m_stap : (m_ptr + 1) % N;
    if (nptr / 256 != old_msb) m_gap = 0;
    else if (m_gap < 255) m_gap++;
    m_ptr = nptr;
    if (done) begin
      if (m_full) begin m_dir = m_rd; m_primed = 1; m_split = 0; end
      else begin m_split = 1; m_stap = m_tap % 256; end
      m_busy = 0;
    end else if (m_busy) m_cnt++;
    if (accept) begin
      m_busy = 1; m_cnt = 0; m_full = !is_split; m_rd = !is_wr;
      m_tap = int'(cmd_tap); m_half = 1 - old_msb; m_last = is_split ? 255 : 511;
    end
    m_err = cmd_valid && refuse;
  endtask

  task automatic check(string req, int got, int exp);
    vecs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
    end
  endtask

  task automatic compare();
    int exp_d;
    exp_d = (ser_en && m_dir) ? m_buf[m_ptr] % 256 : 0;
    check("R2 R3 ser_dout", int'(ser_dout), exp_d);
    check("R5 R6 half_flag", int'(half_flag), m_ptr / 256);
    check("R4 ser_dir", int'(ser_dir), int'(m_dir));
    check("R1 R7 R8 xfer_ready", int'(xfer_ready), int'(!m_busy));
    check("R9 R10 R11 R12 cmd_err", int'(cmd_err), int'(m_err));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n, bit sc, bit en, int stride);
    for (int i = 0; i < n; i++) begin
      sc_pulse = sc && (i % stride == 0);
      ser_en   = en;
      ser_din  = 8'((vecs * 13 + 5) % 256);
      tick();
    end
    sc_pulse = 1'b0;
  endtask

  task automatic issue(int kind, int tap);
    cmd_valid = 1'b1;
    cmd_kind  = 2'(kind);
    cmd_tap   = 9'(tap);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic bump_rows();
    env_op = 2;
    @(posedge clk);
    for (int i = 0; i < N; i++) m_row[i] = (m_row[i] + 64) % 256;
    @(negedge clk);
    env_op = 0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 2'b00; cmd_tap = '0; gap_min = '0;
    sc_pulse = 1'b0; ser_en = 1'b0; ser_din = '0;
    m_ptr = 0; m_gap = 0; m_cnt = 0; m_last = 0; m_tap = 0; m_half = 0; m_stap = 0;
    m_dir = 1; m_primed = 0; m_split = 0; m_busy = 0; m_full = 0; m_rd = 0; m_err = 0;
    for (int i = 0; i < N; i++) begin m_row[i] = (i * 7 + 3) % 256; m_buf[i] = 0; end
    env_op = 1;
    repeat (3) @(negedge clk);
    env_op = 0;
    // R13: reset values
    check("R13 xfer_ready", int'(xfer_ready), 1);
    check("R13 cmd_err", int'(cmd_err), 0);
    check("R13 ser_dir", int'(ser_dir), 1);
    check("R13 half_flag", int'(half_flag), 0);
    rst_n = 1'b1;
    m_hold = 2;
    run(3, 0, 0, 1);

    // R10: split before any full transfer
    issue(2, 5);
    run(2, 0, 0, 1);

    // R1 R2 R3 R5: full read from tap 500, pulses during it ignored
    issue(0, 500);
    run(512, 1, 0, 3);
    run(20, 1, 1, 1);
    run(6, 1, 0, 1);
    run(8, 1, 1, 2);

    // R12: command while busy
    issue(0, 10);
    issue(0, 20);
    run(520, 0, 1, 1);

    // R10 R9: split write in output mode, split taps at end of half
    issue(3, 3);
    issue(2, 9'h0FF);
    issue(2, 9'h1FF);
    run(2, 0, 1, 1);

    // R11: gap after a half change
    issue(0, 255);
    run(512, 0, 0, 1);
    gap_min = 8'd100;
    run(1, 1, 1, 1);
    issue(2, 9'h020);
    run(100, 0, 1, 1);
    bump_rows();
    // R7: split read of lower half while upper streams
    issue(2, 9'h020);
    run(256, 1, 1, 2);
    // R6: jump at end of upper half
    run(140, 1, 1, 1);
    run(110, 0, 1, 1);
    bump_rows();
    issue(2, 9'h080);
    run(256, 1, 1, 4);
    run(200, 1, 1, 1);

    // R8 R4: full write, then serial writes in input mode
    gap_min = 8'd0;
    issue(1, 3);
    run(512, 1, 1, 5);
    issue(2, 9'h010);
    run(30, 1, 1, 1);
    run(5, 1, 0, 1);
    issue(3, 9'h040);
    run(256, 1, 1, 3);
    issue(1, 0);
    run(512, 0, 0, 1);
    issue(0, 0);
    run(512, 0, 0, 1);
    run(40, 1, 1, 1);

    // R8: row contents after all write transfers
    bad = 0;
    for (int i = 0; i < N; i++) if (int'(row_mem[i]) != m_row[i]) bad++;
    check("R8 row contents mismatches", bad, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule